// File: doc/BRIEF.md
# Alternating Compute/Exchange Phase Sequencer

This controller drives an array of worker nodes through a repeating pair of phases: a calculation phase, in which every worker computes on its own data, and an exchange phase, in which results are passed between workers. Each phase is tracked by its own process state machine. The two machines are interlocked so that only one of them is ever busy. A phase ends at a barrier, which is reached once every enabled worker has raised its done flag.

A supervisor starts a run with a one-cycle start command. It ends a run with a stop command, which takes effect at the next handover between phases. Between phases, the controller opens a coordination window. That window stays open until an external acknowledge arrives. Each activation sends the workers a one-cycle start pulse that is tagged with the phase type. A watchdog flags a phase that runs longer than a programmable limit without reaching its barrier.

Top module: `phase_seq`

## Requirements
- R1: After reset both process state outputs read 0 (deleted), and `running`, `phase_go`, `coord_win` and `wdog_err` are low.
- R2: State codes are 0 deleted, 1 ready, 2 active, 3 blocked. A `cmd_start` seen while idle makes the calculation process ready and the exchange process blocked at the next edge, and it clears `wdog_err`. A `cmd_start` seen while running has no effect.
- R3: While running, exactly one process is busy (ready or active), and the other one is blocked.
- R4: A ready process turns active at the edge after a cycle in which `coord_ack` is high. Without the acknowledge it stays ready, so the ready state lasts at least one cycle.
- R5: An active process becomes blocked at the edge that samples all enabled workers done. At that same edge, the other process moves from blocked to ready. Each process therefore follows the order ready, active, blocked.
- R6: A worker whose `enable_i` bit is 0 counts as done. Done inputs are ignored unless a process is active.
- R7: `phase_go` is high for exactly the first cycle of every active state. In that cycle, `phase_is_xchg` is 0 for a calculation phase and 1 for an exchange phase.
- R8: `coord_win` is high exactly while a process is ready.
- R9: A `cmd_stop` is held until a process is ready. At the next edge after that, both processes return to 0 and `running` falls, even if `coord_ack` is high.
- R10: If `wdog_limit` is nonzero, `wdog_err` rises once a phase has spent `wdog_limit` active cycles without reaching its barrier. It stays high until the next start. A limit of 0 disables the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Begin a run (honoured when idle) |
| cmd_stop | input | 1 | Terminate the run at the next ready slot |
| coord_ack | input | 1 | Coordination done, activate the ready process |
| done_i | input | N | Per-worker done flags |
| enable_i | input | N | Per-worker enable mask |
| wdog_limit | input | WDOG_W | Active-phase cycle limit, 0 disables |
| calc_state | output | 2 | Calculation process state code |
| xchg_state | output | 2 | Exchange process state code |
| phase_go | output | 1 | One-cycle phase start strobe |
| phase_is_xchg | output | 1 | Phase type tag for the strobe |
| coord_win | output | 1 | Coordination window open |
| running | output | 1 | A run is in progress |
| wdog_err | output | 1 | Active phase overran its limit |

## Verification
Every result is registered. A command, acknowledge or barrier sampled at one rising edge therefore shows up on the state codes, `phase_go`, `coord_win` and `running` right after that edge. `wdog_err` rises after the edge that ends the `wdog_limit`-th active cycle without a barrier. The bench changes inputs on falling edges and feeds the same inputs, at each rising edge, to a behavioural model that tracks only the current process and its stage. It compares every output against that model on the next falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/phase_seq.sv
module phase_seq #(
  parameter int N      = 8,
  parameter int WDOG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              coord_ack,
  input  logic [N-1:0]      done_i,
  input  logic [N-1:0]      enable_i,
  input  logic [WDOG_W-1:0] wdog_limit,
  output logic [1:0]        calc_state,
  output logic [1:0]        xchg_state,
  output logic              phase_go,
  output logic              phase_is_xchg,
  output logic              coord_win,
  output logic              running,
  output logic              wdog_err
);
  localparam logic [1:0] ST_OFF = 2'd0, ST_RDY = 2'd1, ST_ACT = 2'd2, ST_BLK = 2'd3;
  localparam logic [WDOG_W-1:0] CNT_MAX = {WDOG_W{1'b1}};

  logic              stop_pend;
  logic [WDOG_W-1:0] act_cnt;
  logic              all_done, any_ready, any_active, stopping, wd_hit;

  assign all_done   = &(done_i | ~enable_i);
  assign any_ready  = (calc_state == ST_RDY) || (xchg_state == ST_RDY);
  assign any_active = (calc_state == ST_ACT) || (xchg_state == ST_ACT);
  assign stopping   = stop_pend | cmd_stop;
  assign running    = (calc_state != ST_OFF);
  assign coord_win  = any_ready;
  assign wd_hit     = (wdog_limit != '0) &&
                      ({1'b0, act_cnt} + 1'b1 == {1'b0, wdog_limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      calc_state    <= ST_OFF;
      xchg_state    <= ST_OFF;
      stop_pend     <= 1'b0;
      phase_go      <= 1'b0;
      phase_is_xchg <= 1'b0;
      act_cnt       <= '0;
      wdog_err      <= 1'b0;
    end else begin
      phase_go <= 1'b0;
      if (!running) begin
        if (cmd_start) begin
          calc_state <= ST_RDY;
          xchg_state <= ST_BLK;
          stop_pend  <= 1'b0;
          wdog_err   <= 1'b0;
        end
      end else begin
        if (cmd_stop) stop_pend <= 1'b1;
        if (any_ready) begin
          if (stopping) begin
            calc_state <= ST_OFF;
            xchg_state <= ST_OFF;
            stop_pend  <= 1'b0;
          end else if (coord_ack) begin
            if (calc_state == ST_RDY) begin
              calc_state    <= ST_ACT;
              phase_is_xchg <= 1'b0;
            end else begin
              xchg_state    <= ST_ACT;
              phase_is_xchg <= 1'b1;
            end
            phase_go <= 1'b1;
            act_cnt  <= '0;
          end
        end else if (any_active) begin
          if (all_done) begin
            if (calc_state == ST_ACT) begin
              calc_state <= ST_BLK;
              xchg_state <= ST_RDY;
            end else begin
              xchg_state <= ST_BLK;
              calc_state <= ST_RDY;
            end
          end else begin
            if (wd_hit) wdog_err <= 1'b1;
            if (act_cnt != CNT_MAX) act_cnt <= act_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/phase_seq_chk.sv
module phase_seq_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   calc_state,
  input logic [1:0]   xchg_state,
  input logic         phase_go,
  input logic         coord_ack,
  input logic         cmd_stop,
  input logic [N-1:0] done_i,
  input logic [N-1:0] enable_i
);
  logic c_busy, x_busy, c_rdy, x_rdy;
  assign c_busy = (calc_state == 2'd1) || (calc_state == 2'd2);
  assign x_busy = (xchg_state == 2'd1) || (xchg_state == 2'd2);
  assign c_rdy  = (calc_state == 2'd1);
  assign x_rdy  = (xchg_state == 2'd1);

  // R3
  one_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(c_busy && x_busy));

  // R7
  go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_go |=> !phase_go);

  // R5
  barrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_state == 2'd2 && (&(done_i | ~enable_i))) |=> (calc_state == 2'd3 && xchg_state == 2'd1));

  // R5
  active_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_state == 2'd2) |=> (xchg_state == 2'd2 || xchg_state == 2'd3));

  // R4
  hold_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((c_rdy || x_rdy) && !coord_ack && !cmd_stop) |=> (calc_state != 2'd2 && xchg_state != 2'd2));
endmodule

bind phase_seq phase_seq_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .calc_state(calc_state), .xchg_state(xchg_state),
  .phase_go(phase_go), .coord_ack(coord_ack), .cmd_stop(cmd_stop),
  .done_i(done_i), .enable_i(enable_i)
);

// File: tb/tb_phase_seq.sv
module tb_phase_seq;
  localparam int N = 8;
  localparam int W = 8;

  logic clk = 0, rst_n = 0;
  logic cmd_start = 0, cmd_stop = 0, coord_ack = 0;
  logic [N-1:0] done_i = '0, enable_i = '1;
  logic [W-1:0] wdog_limit = '0;
  logic [1:0] calc_state, xchg_state;
  logic phase_go, phase_is_xchg, coord_win, running, wdog_err;

  always #4 clk = ~clk;

  phase_seq #(.N(N), .WDOG_W(W)) dut (.*);

  int tests = 0, fails = 0, cyc = 0;
  bit done_run = 0;

  // reference: cur process (0 calc, 1 exchange), stage 0 off / 1 ready / 2 active
  int m_stage = 0, m_cur = 0, m_cnt = 0;
  bit m_stop = 0, m_go = 0, m_isx = 0, m_err = 0;

  function automatic int st_of(int who);
    if (m_stage == 0) return 0;
    return (who == m_cur) ? m_stage : 3;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stage = 0; m_cur = 0; m_cnt = 0; m_stop = 0; m_go = 0; m_isx = 0; m_err = 0;
    end else begin
      bit now_stop;
      m_go = 0;
      if (m_stage == 0) begin
        if (cmd_start) begin m_stage = 1; m_cur = 0; m_stop = 0; m_err = 0; end
      end else begin
        now_stop = m_stop || cmd_stop;
        if (cmd_stop) m_stop = 1;
        if (m_stage == 1) begin
          if (now_stop) begin m_stage = 0; m_stop = 0; end
          else if (coord_ack) begin m_stage = 2; m_go = 1; m_isx = (m_cur == 1); m_cnt = 0; end
        end else begin
          if ((done_i | ~enable_i) == {N{1'b1}}) begin m_cur = 1 - m_cur; m_stage = 1; end
          else begin
            m_cnt++;
            if (wdog_limit != 0 && m_cnt == int'(wdog_limit)) m_err = 1;
          end
        end
      end
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cyc++;
    check("R5 calc_state", calc_state, st_of(0));
    check("R5 xchg_state", xchg_state, st_of(1));
    check("R7 phase_go", phase_go, m_go);
    if (m_go) check("R7 phase_is_xchg", phase_is_xchg, m_isx);
    check("R8 coord_win", coord_win, m_stage == 1);
    check("R9 running", running, m_stage != 0);
    check("R10 wdog_err", wdog_err, m_err);
    if (running) check("R3 one busy", ((calc_state == 1 || calc_state == 2) ? 1 : 0) +
                                      ((xchg_state == 1 || xchg_state == 2) ? 1 : 0), 1);
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    tick(2);
    // R1
    check("R1 calc_state", calc_state, 0);
    check("R1 xchg_state", xchg_state, 0);
    check("R1 outputs", {running, phase_go, coord_win, wdog_err}, 0);
    rst_n = 1;
    tick();
    // R2 start
    cmd_start = 1; tick(); cmd_start = 0;
    check("R2 calc ready", calc_state, 1);
    check("R2 xchg blocked", xchg_state, 3);
    // R6 done ignored while ready, R4 hold without ack
    done_i = '1; tick(3);
    check("R4 still ready", calc_state, 1);
    check("R6 done ignored", xchg_state, 3);
    // R2 start while running ignored
    cmd_start = 1; tick(); cmd_start = 0;
    check("R2 start ignored", calc_state, 1);
    done_i = '0; coord_ack = 1; tick(); coord_ack = 0;
    check("R4 active", calc_state, 2);
    check("R7 go calc", {phase_go, phase_is_xchg}, 2);
    // R6 disabled worker counts done
    enable_i = 8'hFE; done_i = 8'h7E; tick();
    check("R6 partial", calc_state, 2);
    done_i = 8'hFE; tick();
    check("R6 masked barrier", {calc_state, xchg_state}, 4'b1101);
    done_i = '0; enable_i = '1;
    coord_ack = 1; tick(); coord_ack = 0;
    check("R7 go xchg", {phase_go, phase_is_xchg}, 3);
    // R10 watchdog
    wdog_limit = 5; tick(4);
    check("R10 before limit", wdog_err, 0);
    tick();
    check("R10 at limit", wdog_err, 1);
    // R9 stop during active applies at ready
    cmd_stop = 1; tick(); cmd_stop = 0;
    check("R9 still running", running, 1);
    done_i = '1; tick(); done_i = '0;
    check("R9 ready", calc_state, 1);
    coord_ack = 1; tick(); coord_ack = 0;
    check("R9 stopped", {calc_state, xchg_state, running}, 0);
    check("R10 err held", wdog_err, 1);
    cmd_start = 1; tick(); cmd_start = 0;
    check("R10 cleared by start", wdog_err, 0);
    // random traffic, compared against model each cycle
    for (int i = 0; i < 6000; i++) begin
      cmd_start  = ($urandom % 20) == 0;
      cmd_stop   = ($urandom % 60) == 0;
      coord_ack  = ($urandom % 3) == 0;
      enable_i   = (($urandom % 4) == 0) ? N'($urandom) : '1;
      done_i     = (($urandom % 3) == 0) ? '1 : N'($urandom);
      if (i % 1500 == 0) wdog_limit = W'(($urandom % 3) * 4);
      tick();
    end
    done_run = 1;
  end

  initial begin
    int w = 0;
    while (!done_run && w < 100000) begin @(posedge clk); w++; end
    if (!done_run) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule